// File: doc/BRIEF.md
# Inbound Memory Window Decoder

This block sits on the target side of a host bridge. It holds three programmable inbound windows. Each window is a 32-bit register that packs a bus-side base address and a power-of-two size code. Every bus address presented on the lookup port is compared against all enabled windows at once. One cycle later the block reports whether the address hit, which window won, and the local memory address.

Every window maps onto local address zero. The local address is therefore the offset of the bus address inside the window. The window registers are loaded through a simple write port that takes a byte offset. Forwarding the transaction itself is left to the logic around the block.

The result stage is a small state machine with three named states:
- `RS_IDLE`: no result is being reported.
- `RS_HIT`: a valid result that matched a window.
- `RS_MISS`: a valid result that matched no window.

From any state, the clock edge follows one of three transitions:
- **go_idle**: no lookup is presented, so the next state is `RS_IDLE`.
- **take_hit**: a lookup matches at least one window, so the next state is `RS_HIT`.
- **take_miss**: a lookup matches no window, so the next state is `RS_MISS`.

Top module: `inbound_win_decoder`

## Requirements
- R1: After reset no result is valid, and every window is disabled, so any lookup misses.
- R2: A write at byte offset 0x50 + 4*i loads window i (i = 0, 1, 2). Bits 31:20 of the written data are the base and bits 19:16 are the size code. A write at any other offset changes no window.
- R3: A size code c from 0 to 11 gives a window of 2^(20+c) bytes. Code 0 is 1 MB and code 11 is 2 GB. An address one past the window end misses.
- R4: Size codes 12 to 15 disable the window, so it never hits.
- R5: Written bits 15:0 are dropped. Base bits below the window size are ignored in the compare, so a window with an unaligned base decodes as the naturally aligned window that contains that base.
- R6: On a hit, the local address equals the bus address modulo the window size (local base zero), and its bit 31 is 0.
- R7: When several windows match, the lowest-numbered one is reported.
- R8: On a miss, the hit output is 0, and the window index and local address are 0.
- R9: A lookup presented at one clock edge gives a valid result after that edge, for exactly one cycle per lookup. Back-to-back lookups give back-to-back results. With no lookup, the valid output is low.
- R10: A window write is used by a lookup presented on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr_en | input | 1 | Window register write strobe |
| cfg_wr_ofs | input | 8 | Byte offset of the register written |
| cfg_wr_data | input | 32 | Write data: base in 31:20, size code in 19:16 |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 32 | Bus-side address to decode |
| rs_valid | output | 1 | Result valid, one cycle after the request |
| rs_hit | output | 1 | Address fell in an enabled window |
| rs_win | output | IDX_W (2) | Index of the winning window |
| rs_local | output | 32 | Translated local address |

## Verification
The bench builds the block with its default three windows and register base 0x50. With these values, overlapping windows can exercise the priority order, and the disabled size codes can expose a lower-priority window behind them. The 32-bit address width lets the largest 2 GB code reach the top of the address space, so the widest mask and the highest local offset are both covered. An unaligned base with junk in its low bits shows that the compare is aligned to the window size.

// File: rtl/win_dec_pkg.sv
package win_dec_pkg;
    localparam int ADDR_W   = 32;
    localparam int BASE_LSB = 20;
    localparam int CODE_W   = 4;
    localparam int CODE_LSB = 16;
    localparam int OFS_W    = 8;
    localparam int BASE_W   = ADDR_W - BASE_LSB;
    localparam int MAX_CODE = ADDR_W - 1 - BASE_LSB;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [CODE_W-1:0] code;
    } win_cfg_t;

    typedef enum logic [1:0] {
        RS_IDLE,
        RS_HIT,
        RS_MISS
    } res_state_e;

    // ones on every address bit that lies inside a window of the given code
    function automatic logic [ADDR_W-1:0] span_mask(input logic [CODE_W-1:0] code);
        logic [ADDR_W-1:0] m;
        for (int b = 0; b < ADDR_W; b++) begin
            m[b] = (b < BASE_LSB + int'(code));
        end
        return m;
    endfunction
endpackage

// File: rtl/win_cfg_regs.sv
module win_cfg_regs
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter logic [OFS_W-1:0] REG_BASE = 8'h50
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [OFS_W-1:0]          wr_ofs,
    input  logic [ADDR_W-1:0]         wr_data,
    output win_cfg_t [NUM_WIN-1:0]    cfg_o
);
    for (genvar i = 0; i < NUM_WIN; i++) begin : g_reg
        localparam logic [OFS_W-1:0] MY_OFS = OFS_W'(int'(REG_BASE) + 4 * i);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_o[i].base <= '0;
                cfg_o[i].code <= '1;
            end else if (wr_en && wr_ofs == MY_OFS) begin
                cfg_o[i].base <= wr_data[ADDR_W-1:BASE_LSB];
                cfg_o[i].code <= wr_data[CODE_LSB +: CODE_W];
            end
        end
    end
endmodule

// File: rtl/win_match.sv
module win_match
    import win_dec_pkg::*;
(
    input  win_cfg_t            cfg,
    input  logic [ADDR_W-1:0]   addr,
    output logic                hit,
    output logic [ADDR_W-1:0]   local_addr
);
    logic [ADDR_W-1:0] low_m;
    logic [ADDR_W-1:0] base_full;
    logic              enabled;

    always_comb begin
        enabled    = (int'(cfg.code) <= MAX_CODE);
        low_m      = span_mask(cfg.code);
        base_full  = {cfg.base, {BASE_LSB{1'b0}}};
        hit        = enabled && (((addr ^ base_full) & ~low_m) == '0);
        local_addr = addr & low_m;
    end
endmodule

// File: rtl/win_select.sv
module win_select
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter int IDX_W   = 2
) (
    input  logic [NUM_WIN-1:0]             hit_v,
    input  logic [NUM_WIN-1:0][ADDR_W-1:0] local_v,
    output logic                           any_hit,
    output logic [IDX_W-1:0]               idx,
    output logic [ADDR_W-1:0]              local_addr
);
    always_comb begin
        any_hit    = 1'b0;
        idx        = '0;
        local_addr = '0;
        // scan downward so the lowest index is written last and wins
        for (int i = NUM_WIN - 1; i >= 0; i--) begin
            if (hit_v[i]) begin
                any_hit    = 1'b1;
                idx        = IDX_W'(i);
                local_addr = local_v[i];
            end
        end
    end
endmodule

// File: rtl/inbound_win_decoder.sv
module inbound_win_decoder
    import win_dec_pkg::*;
#(
    parameter int NUM_WIN = 3,
    parameter logic [7:0] REG_BASE = 8'h50,
    parameter int IDX_W = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [7:0]        cfg_wr_ofs,
    input  logic [31:0]       cfg_wr_data,
    input  logic              lk_valid,
    input  logic [31:0]       lk_addr,
    output logic              rs_valid,
    output logic              rs_hit,
    output logic [IDX_W-1:0]  rs_win,
    output logic [31:0]       rs_local
);
    win_cfg_t [NUM_WIN-1:0]             cfg;
    logic [NUM_WIN-1:0]                 hit_v;
    logic [NUM_WIN-1:0][ADDR_W-1:0]     local_v;
    logic                               any_hit;
    logic [IDX_W-1:0]                   sel_idx;
    logic [ADDR_W-1:0]                  sel_local;

    res_state_e        state_q, state_d;
    logic [IDX_W-1:0]  win_q;
    logic [ADDR_W-1:0] loc_q;

    win_cfg_regs #(.NUM_WIN(NUM_WIN), .REG_BASE(REG_BASE)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_ofs  (cfg_wr_ofs),
        .wr_data (cfg_wr_data),
        .cfg_o   (cfg)
    );

    for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
        win_match u_match (
            .cfg        (cfg[i]),
            .addr       (lk_addr),
            .hit        (hit_v[i]),
            .local_addr (local_v[i])
        );
    end

    win_select #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_sel (
        .hit_v      (hit_v),
        .local_v    (local_v),
        .any_hit    (any_hit),
        .idx        (sel_idx),
        .local_addr (sel_local)
    );

    // next-state: go_idle / take_hit / take_miss, identical from every state
    always_comb begin
        state_d = RS_IDLE;
        unique case (state_q)
            RS_IDLE, RS_HIT, RS_MISS: begin
                if (!lk_valid)    state_d = RS_IDLE;
                else if (any_hit) state_d = RS_HIT;
                else              state_d = RS_MISS;
            end
            default: state_d = RS_IDLE;
        endcase
    end

    // state register with the captured result
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
            win_q   <= '0;
            loc_q   <= '0;
        end else begin
            state_q <= state_d;
            win_q   <= (lk_valid && any_hit) ? sel_idx : '0;
            loc_q   <= (lk_valid && any_hit) ? sel_local : '0;
        end
    end

    // outputs decoded from the state
    always_comb begin
        rs_valid = 1'b0;
        rs_hit   = 1'b0;
        rs_win   = '0;
        rs_local = '0;
        unique case (state_q)
            RS_IDLE: ;
            RS_HIT: begin
                rs_valid = 1'b1;
                rs_hit   = 1'b1;
                rs_win   = win_q;
                rs_local = loc_q;
            end
            RS_MISS: rs_valid = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/win_decoder_chk.sv
module win_decoder_chk #(
    parameter int NUM_WIN = 3,
    parameter int IDX_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             lk_valid,
    input logic             rs_valid,
    input logic             rs_hit,
    input logic [IDX_W-1:0] rs_win,
    input logic [31:0]      rs_local
);
    // R9
    req_to_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> rs_valid);
    // R9
    no_req_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> !rs_valid);
    // R8
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rs_valid && !rs_hit) |-> (rs_win == '0 && rs_local == '0));
    // R7
    win_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_hit |-> (rs_valid && int'(rs_win) < NUM_WIN));
    // R6
    local_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rs_valid |-> !rs_local[31]);
endmodule

bind inbound_win_decoder win_decoder_chk #(.NUM_WIN(NUM_WIN), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_valid (lk_valid),
    .rs_valid (rs_valid),
    .rs_hit   (rs_hit),
    .rs_win   (rs_win),
    .rs_local (rs_local)
);

// File: tb/tb_inbound_win_decoder.sv
module tb_inbound_win_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [7:0]  cfg_wr_ofs = '0;
    logic [31:0] cfg_wr_data = '0;
    logic        lk_valid = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        rs_valid, rs_hit;
    logic [1:0]  rs_win;
    logic [31:0] rs_local;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic        hit;
        logic [1:0]  win;
        logic [31:0] loc;
        string       req;
    } exp_t;
    exp_t sb[$];

    logic [31:0] mdl [3];

    always #5 clk = ~clk;

    inbound_win_decoder dut (
        .clk(clk), .rst_n(rst_n),
        .cfg_wr_en(cfg_wr_en), .cfg_wr_ofs(cfg_wr_ofs), .cfg_wr_data(cfg_wr_data),
        .lk_valid(lk_valid), .lk_addr(lk_addr),
        .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_win(rs_win), .rs_local(rs_local)
    );

    function automatic exp_t predict(input logic [31:0] a, input string req);
        exp_t e;
        e.hit = 0; e.win = 0; e.loc = 0; e.req = req;
        for (int i = 2; i >= 0; i--) begin
            int c;
            c = int'(mdl[i][19:16]);
            if (c <= 11) begin
                int sh;
                logic [63:0] lowm;
                sh = 20 + c;
                lowm = (64'd1 << sh) - 64'd1;
                if ((64'(a) >> sh) == (64'(mdl[i] & 32'hFFF0_0000) >> sh)) begin
                    e.hit = 1; e.win = 2'(i); e.loc = a & lowm[31:0];
                end
            end
        end
        return e;
    endfunction

    task automatic wr(input logic [7:0] ofs, input logic [31:0] d);
        @(negedge clk);
        lk_valid = 0;
        cfg_wr_en = 1; cfg_wr_ofs = ofs; cfg_wr_data = d;
        for (int i = 0; i < 3; i++)
            if (ofs == 8'(8'h50 + 4 * i)) mdl[i] = d;
        @(negedge clk);
        cfg_wr_en = 0;
    endtask

    task automatic lookup(input logic [31:0] a, input string req);
        @(negedge clk);
        lk_valid = 1; lk_addr = a;
        sb.push_back(predict(a, req));
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lk_valid = 0;
        end
    endtask

    // monitor: compare each valid result against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && rs_valid) begin
            exp_t e;
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R9 unexpected result: got valid=1 expected valid=0");
            end else begin
                e = sb.pop_front();
                if (rs_hit !== e.hit || rs_win !== e.win || rs_local !== e.loc) begin
                    errors++;
                    $display("FAIL %s: got hit=%0b win=%0d local=%h expected hit=%0b win=%0d local=%h",
                             e.req, rs_hit, rs_win, rs_local, e.hit, e.win, e.loc);
                end
            end
        end
    end

    task automatic expect_idle(input string req);
        @(negedge clk);
        checks++;
        if (rs_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: got valid=%0b expected valid=0", req, rs_valid);
        end
    endtask

    initial begin
        for (int i = 0; i < 3; i++) mdl[i] = 32'h000F_0000;
        repeat (3) @(negedge clk);
        rst_n = 1;
        expect_idle("R1 reset valid");
        lookup(32'h0000_0000, "R1 all windows disabled");
        lookup(32'h1000_0000, "R1 all windows disabled");
        idle(2);
        expect_idle("R9 idle after lookups");

        // R2 R10 window 0: 1 MB at 0x1000_0000
        wr(8'h50, 32'h1000_0000);
        lookup(32'h1000_1234, "R2 R10 win0 hit");
        lookup(32'h100F_FFFF, "R3 1MB last byte");
        lookup(32'h1010_0000, "R3 R8 one past 1MB");
        lookup(32'h0FFF_FFFF, "R8 below base");
        // R2 window 1: 8 MB at 0x4000_0000
        wr(8'h54, 32'h4003_0000);
        lookup(32'h407F_FFFC, "R3 R6 8MB top");
        lookup(32'h4080_0000, "R3 one past 8MB");
        // R5 unaligned base with junk low bits, 4 MB
        wr(8'h58, 32'h8032_ABCD);
        lookup(32'h8000_0010, "R5 aligned-down base");
        lookup(32'h803F_FFFF, "R5 R6 last byte");
        lookup(32'h8040_0000, "R5 one past");
        // R7 overlap: window 1 becomes 16 MB at 0x1000_0000
        wr(8'h54, 32'h1004_0000);
        lookup(32'h1000_0040, "R7 lowest index wins");
        lookup(32'h1050_0000, "R7 only win1");
        // R4 disable window 0 with each disabled code
        for (int c = 12; c < 16; c++) begin
            wr(8'h50, 32'h1000_0000 | (32'(c) << 16));
            lookup(32'h1000_0040, "R4 disabled code");
        end
        // R3 largest code 2 GB
        wr(8'h58, 32'h800B_0000);
        lookup(32'hFFFF_FFF0, "R3 R6 2GB top");
        lookup(32'h7000_0000, "R3 below 2GB");
        // R2 writes at foreign offsets change nothing
        wr(8'h5C, 32'h2000_0000);
        wr(8'h4C, 32'h2000_0000);
        wr(8'h51, 32'h2000_0000);
        lookup(32'h2000_0000, "R2 foreign offset ignored");
        lookup(32'h1000_0040, "R2 window 1 unchanged");
        idle(1);
        expect_idle("R9 no request");
        idle(2);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R9 missing results: got %0d pending expected 0", sb.size());
        end
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL R9 watchdog: got hung run expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule